// File: doc/BRIEF.md
# Block Copy and Search Engine

This engine runs string-style memory operations over a synchronous byte memory port. Software-visible state lives in four registers: a source pointer, a destination pointer, a 16-bit iteration count and an 8-bit key byte that searches use. These are loaded together with a flag byte when a command starts. A command selects copy or search, single-step or auto-repeat, and upward or downward stepping.

A copy iteration reads the byte at the source pointer and writes it to the destination pointer. Both pointers then move one place in the chosen direction and the count drops by one. A search iteration reads the byte at the source pointer and subtracts it from the key, keeping only the flags. The source pointer then moves and the count drops. Repeating copies end when the count reaches zero. Repeating searches end on the first equal byte or when the count reaches zero, whichever comes first. The final pointers, count and flags stay on the outputs, and a one-cycle done pulse marks the end of the command.

Top module: `blk_xfer_engine`

## Requirements
- R1: Out of reset and whenever idle, `busy`, `done` and `memReq` are 0.
- R2: A copy iteration reads the byte at `srcPtr`, writes it to `dstPtr` and decrements `count` by one. With `cmdDown`=0, both pointers then advance by +1.
- R3: With `cmdDown`=1, both pointers step by -1 after each iteration, wrapping through 0x0000 to 0xFFFF.
- R4: A repeating copy iterates until `count` is zero. It ends with flag bits 4, 2 and 1 all 0.
- R5: Flag byte layout: bit7 sign, bit6 zero, bit4 half-borrow, bit2 count-live, bit1 subtract marker, bit0 carry. Bits 5 and 3 pass through. A copy iteration clears bits 4 and 1, and sets bit 2 to 1 exactly when the decremented count is nonzero. Bits 7, 6 and 0 are left unchanged.
- R6: A search iteration computes key minus byte. It sets bit7 to the result's MSB, bit6 to (result==0) and bit4 to (low nibble of key < low nibble of byte). Bit2 is set to (decremented count != 0), bit1 to 1, and bit0 is left unchanged. Searches never write memory.
- R7: A repeating search stops after the first iteration whose byte equals the key, or after the iteration that takes `count` to zero.
- R8: A starting count of 0 is decremented to 0xFFFF before the zero test, so it allows 65536 iterations.
- R9: `memReq` and `memWe` form a request that is held with `memAddr`, `memWe` and `memWdata` stable until `memReady` is 1. Read data is taken from `memRdata` in the cycle after the read is accepted.
- R10: `done` is a single-cycle pulse in the cycle the results are final. `cmdStart` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start a command (taken only when idle) |
| cmdSearch | input | 1 | 1 = search, 0 = copy |
| cmdRepeat | input | 1 | 1 = auto-repeat, 0 = one iteration |
| cmdDown | input | 1 | 1 = pointers step down, 0 = up |
| srcIn | input | 16 | Initial source pointer |
| dstIn | input | 16 | Initial destination pointer |
| cntIn | input | 16 | Initial count |
| keyIn | input | 8 | Search key byte |
| flagsIn | input | 8 | Initial flag byte |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Write data |
| memReady | input | 1 | Request accepted this cycle |
| memRdata | input | 8 | Read data, valid the cycle after acceptance |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| srcPtr | output | 16 | Current source pointer |
| dstPtr | output | 16 | Current destination pointer |
| count | output | 16 | Current count |
| flagsOut | output | 8 | Current flag byte |

## Verification
Copies are tried upward and downward, single-step and repeating, both with a memory that is always ready and with one that stalls every other cycle. Stalled copies show that request holding and data capture do not depend on timing. Searches are fed byte patterns that expose each flag separately: a positive nonzero difference with a nibble borrow, an exact match, and a negative difference. Repeating searches are run with an early match, with no match, and with a zero start count that walks the pointer across address zero, which separates the two stop conditions and the count wrap. A restart attempted mid-command shows that the running command's results are unchanged.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int FLAG_S  = 7;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_H  = 4;
  localparam int FLAG_PV = 2;
  localparam int FLAG_N  = 1;
  localparam int FLAG_C  = 0;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_DATA,
    ST_WRITE
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic latchData;
    logic stepCopy;
    logic stepCmp;
    logic addrDst;
  } dpCtl_t;
endpackage

// File: rtl/blk_xfer_datapath.sv
module blk_xfer_datapath
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              cmdDown,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [DATA_W-1:0] keyIn,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              cntZeroNext,
  output logic              byteMatch,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] flagsOut
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam int NIB = 4;

  logic [ADDR_W-1:0] srcReg, dstReg, srcStep, dstStep;
  logic [CNT_W-1:0]  cntReg, cntDec;
  logic [DATA_W-1:0] keyReg, flagReg, dataReg, diff;
  logic              downReg, halfBorrow;

  assign srcStep    = downReg ? srcReg - ADDR_ONE : srcReg + ADDR_ONE;
  assign dstStep    = downReg ? dstReg - ADDR_ONE : dstReg + ADDR_ONE;
  assign cntDec     = cntReg - CNT_ONE;
  assign diff       = keyReg - memRdata;
  assign halfBorrow = keyReg[NIB-1:0] < memRdata[NIB-1:0];

  assign cntZeroNext = (cntDec == '0);
  assign byteMatch   = (keyReg == memRdata);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg  <= '0;
      dstReg  <= '0;
      cntReg  <= '0;
      keyReg  <= '0;
      flagReg <= '0;
      dataReg <= '0;
      downReg <= 1'b0;
    end else if (ctl.load) begin
      srcReg  <= srcIn;
      dstReg  <= dstIn;
      cntReg  <= cntIn;
      keyReg  <= keyIn;
      flagReg <= flagsIn;
      downReg <= cmdDown;
    end else begin
      if (ctl.latchData) dataReg <= memRdata;
      if (ctl.stepCopy) begin
        srcReg          <= srcStep;
        dstReg          <= dstStep;
        cntReg          <= cntDec;
        flagReg[FLAG_H] <= 1'b0;
        flagReg[FLAG_N] <= 1'b0;
        flagReg[FLAG_PV] <= !cntZeroNext;
      end
      if (ctl.stepCmp) begin
        srcReg           <= srcStep;
        cntReg           <= cntDec;
        flagReg[FLAG_S]  <= diff[DATA_W-1];
        flagReg[FLAG_Z]  <= (diff == '0);
        flagReg[FLAG_H]  <= halfBorrow;
        flagReg[FLAG_PV] <= !cntZeroNext;
        flagReg[FLAG_N]  <= 1'b1;
      end
    end
  end

  assign memAddr  = ctl.addrDst ? dstReg : srcReg;
  assign memWdata = dataReg;
  assign srcPtr   = srcReg;
  assign dstPtr   = dstReg;
  assign count    = cntReg;
  assign flagsOut = flagReg;
endmodule

// File: rtl/blk_xfer_control.sv
module blk_xfer_control
  import blk_xfer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdStart,
  input  logic   cmdSearch,
  input  logic   cmdRepeat,
  input  logic   memReady,
  input  logic   cntZeroNext,
  input  logic   byteMatch,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   busy,
  output logic   done
);
  engState_t state, stateNext;
  logic searchReg, repeatReg, finish;

  always_comb begin
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    finish    = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdStart) begin
          ctl.load  = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memReady) stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (searchReg) begin
          ctl.stepCmp = 1'b1;
          if (!repeatReg || byteMatch || cntZeroNext) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_READ;
          end
        end else begin
          ctl.latchData = 1'b1;
          stateNext     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrDst = 1'b1;
        if (memReady) begin
          ctl.stepCopy = 1'b1;
          if (!repeatReg || cntZeroNext) begin
            finish    = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_READ;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      searchReg <= 1'b0;
      repeatReg <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (ctl.load) begin
        searchReg <= cmdSearch;
        repeatReg <= cmdRepeat;
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blk_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdSearch,
  input  logic              cmdRepeat,
  input  logic              cmdDown,
  input  logic [ADDR_W-1:0] srcIn,
  input  logic [ADDR_W-1:0] dstIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [DATA_W-1:0] keyIn,
  input  logic [DATA_W-1:0] flagsIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] flagsOut
);
  dpCtl_t ctl;
  logic   cntZeroNext, byteMatch;

  blk_xfer_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStart   (cmdStart),
    .cmdSearch  (cmdSearch),
    .cmdRepeat  (cmdRepeat),
    .memReady   (memReady),
    .cntZeroNext(cntZeroNext),
    .byteMatch  (byteMatch),
    .ctl        (ctl),
    .memReq     (memReq),
    .memWe      (memWe),
    .busy       (busy),
    .done       (done)
  );

  blk_xfer_datapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdDown    (cmdDown),
    .srcIn      (srcIn),
    .dstIn      (dstIn),
    .cntIn      (cntIn),
    .keyIn      (keyIn),
    .flagsIn    (flagsIn),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .cntZeroNext(cntZeroNext),
    .byteMatch  (byteMatch),
    .srcPtr     (srcPtr),
    .dstPtr     (dstPtr),
    .count      (count),
    .flagsOut   (flagsOut)
  );
endmodule

// File: rtl/blk_xfer_checker.sv
module blk_xfer_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              cmdSearch,
  input logic              busy,
  input logic              done,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memReady
);
  logic searchMode;

  always_ff @(posedge clk) begin
    if (!rstN) searchMode <= 1'b0;
    else if (cmdStart && !busy) searchMode <= cmdSearch;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  a_r9_hold_wdata: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memReady) |=> $stable(memWdata));

  a_r6_search_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (busy && searchMode) |-> !memWe);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind blk_xfer_engine blk_xfer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/blk_xfer_engine_test.sv
module blk_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0, cmdSearch = 1'b0, cmdRepeat = 1'b0, cmdDown = 1'b0;
  logic [15:0] srcIn = '0, dstIn = '0, cntIn = '0;
  logic [7:0]  keyIn = '0, flagsIn = '0;
  logic        memReq, memWe, memReady, busy, done;
  logic [15:0] memAddr, srcPtr, dstPtr, count;
  logic [7:0]  memWdata, memRdata, flagsOut;

  logic [7:0]  mem [0:4095];
  logic [7:0]  rdData = '0;
  logic        readyReg = 1'b1;
  logic        stallOn = 1'b0;
  int          writeCount = 0;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  blk_xfer_engine uut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdSearch(cmdSearch),
    .cmdRepeat(cmdRepeat), .cmdDown(cmdDown), .srcIn(srcIn), .dstIn(dstIn),
    .cntIn(cntIn), .keyIn(keyIn), .flagsIn(flagsIn), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata), .busy(busy), .done(done), .srcPtr(srcPtr),
    .dstPtr(dstPtr), .count(count), .flagsOut(flagsOut)
  );

  assign memReady = readyReg;
  assign memRdata = rdData;

  always @(posedge clk) begin
    readyReg <= stallOn ? ~readyReg : 1'b1;
    if (memReq && memReady) begin
      if (memWe) begin
        mem[memAddr[11:0]] <= memWdata;
        writeCount <= writeCount + 1;
      end else begin
        rdData <= mem[memAddr[11:0]];
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input logic search, input logic rep, input logic down,
                        input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                        input logic [7:0] k, input logic [7:0] f);
    int waitN;
    @(negedge clk);
    cmdSearch = search; cmdRepeat = rep; cmdDown = down;
    srcIn = s; dstIn = d; cntIn = c; keyIn = k; flagsIn = f;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    waitN = 0;
    while (!done && waitN < 5000) begin
      @(negedge clk);
      waitN++;
    end
    check("R10", "done seen", int'(done), 1);
  endtask

  task automatic tReset();
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "memReq after reset", int'(memReq), 0);
  endtask

  task automatic tCopySingle();
    mem[12'h100] = 8'hA5; mem[12'h200] = 8'h00;
    runCmd(1'b0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'd5, 8'h00, 8'hFF);
    check("R2", "dest byte", int'(mem[12'h200]), 'hA5);
    check("R2", "src ptr", int'(srcPtr), 'h0101);
    check("R2", "dst ptr", int'(dstPtr), 'h0201);
    check("R2", "count", int'(count), 4);
    check("R5", "flags live", int'(flagsOut), 'hED);
    @(negedge clk);
    check("R10", "done drops", int'(done), 0);
    check("R1", "idle no req", int'(memReq), 0);
    mem[12'h110] = 8'h3C;
    runCmd(1'b0, 1'b0, 1'b0, 16'h0110, 16'h0210, 16'd1, 8'h00, 8'h17);
    check("R5", "flags last", int'(flagsOut), 'h01);
    check("R5", "count last", int'(count), 0);
  endtask

  task automatic tCopyRepeatUp();
    stallOn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      mem[12'h300 + i] = 8'(8'h40 + i);
      mem[12'h400 + i] = 8'h00;
    end
    mem[12'h406] = 8'hEE;
    runCmd(1'b0, 1'b1, 1'b0, 16'h0300, 16'h0400, 16'd6, 8'h00, 8'hFF);
    for (int i = 0; i < 6; i++)
      check("R4", "repeat copy byte", int'(mem[12'h400 + i]), 'h40 + i);
    check("R4", "no overrun", int'(mem[12'h406]), 'hEE);
    check("R4", "count zero", int'(count), 0);
    check("R4", "end flags", int'(flagsOut), 'hE9);
    check("R9", "src ptr stalled", int'(srcPtr), 'h0306);
    stallOn = 1'b0;
  endtask

  task automatic tCopyRepeatDown();
    for (int i = 0; i < 4; i++) begin
      mem[12'h5FC + i] = 8'(8'h90 + i);
      mem[12'h6FC + i] = 8'h00;
    end
    runCmd(1'b0, 1'b1, 1'b1, 16'h05FF, 16'h06FF, 16'd4, 8'h00, 8'h00);
    for (int i = 0; i < 4; i++)
      check("R3", "down copy byte", int'(mem[12'h6FC + i]), 'h90 + i);
    check("R3", "src ptr down", int'(srcPtr), 'h05FB);
    check("R3", "dst ptr down", int'(dstPtr), 'h06FB);
  endtask

  task automatic tCmpSingle();
    int w0;
    w0 = writeCount;
    mem[12'h700] = 8'h11;
    runCmd(1'b1, 1'b0, 1'b0, 16'h0700, 16'h0000, 16'd3, 8'h20, 8'h01);
    check("R6", "flags borrow nibble", int'(flagsOut), 'h17);
    check("R6", "count", int'(count), 2);
    check("R6", "src ptr", int'(srcPtr), 'h0701);
    mem[12'h701] = 8'h05;
    runCmd(1'b1, 1'b0, 1'b0, 16'h0701, 16'h0000, 16'd1, 8'h05, 8'h00);
    check("R6", "flags equal", int'(flagsOut), 'h42);
    mem[12'h702] = 8'h01;
    runCmd(1'b1, 1'b0, 1'b0, 16'h0702, 16'h0000, 16'd2, 8'h00, 8'h00);
    check("R6", "flags negative", int'(flagsOut), 'h96);
    check("R6", "no writes", writeCount - w0, 0);
  endtask

  task automatic tCmpRepeat();
    mem[12'h800] = 8'h01; mem[12'h801] = 8'h02; mem[12'h802] = 8'h7E; mem[12'h803] = 8'h04;
    runCmd(1'b1, 1'b1, 1'b0, 16'h0800, 16'h0000, 16'd10, 8'h7E, 8'h00);
    check("R7", "match src ptr", int'(srcPtr), 'h0803);
    check("R7", "match count", int'(count), 7);
    check("R7", "match flags", int'(flagsOut), 'h46);
    stallOn = 1'b1;
    mem[12'h900] = 8'h20; mem[12'h901] = 8'h30; mem[12'h902] = 8'h40; mem[12'h903] = 8'h10;
    runCmd(1'b1, 1'b1, 1'b0, 16'h0900, 16'h0000, 16'd3, 8'h10, 8'h00);
    check("R7", "exhaust src ptr", int'(srcPtr), 'h0903);
    check("R7", "exhaust count", int'(count), 0);
    check("R7", "exhaust flags", int'(flagsOut), 'h82);
    stallOn = 1'b0;
  endtask

  task automatic tCmpWrap();
    mem[12'h001] = 8'h00; mem[12'h000] = 8'h00; mem[12'hFFF] = 8'h55;
    runCmd(1'b1, 1'b1, 1'b1, 16'h0001, 16'h0000, 16'd0, 8'h55, 8'h00);
    check("R8", "wrap count", int'(count), 'hFFFD);
    check("R8", "wrap src ptr", int'(srcPtr), 'hFFFE);
    check("R8", "wrap flags", int'(flagsOut), 'h46);
  endtask

  task automatic tBusyIgnore();
    int waitN;
    for (int i = 0; i < 4; i++) begin
      mem[12'hA00 + i] = 8'(8'hC0 + i);
      mem[12'hB00 + i] = 8'h00;
    end
    @(negedge clk);
    cmdSearch = 1'b0; cmdRepeat = 1'b1; cmdDown = 1'b0;
    srcIn = 16'h0A00; dstIn = 16'h0B00; cntIn = 16'd4; flagsIn = 8'h00;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    @(negedge clk);
    srcIn = 16'h0C00; dstIn = 16'h0D00; cntIn = 16'd1; cmdSearch = 1'b1;
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    waitN = 0;
    while (!done && waitN < 5000) begin
      @(negedge clk);
      waitN++;
    end
    check("R10", "done after busy restart", int'(done), 1);
    check("R10", "restart ignored count", int'(count), 0);
    check("R10", "restart ignored dst", int'(dstPtr), 'h0B04);
    check("R10", "restart ignored byte", int'(mem[12'hB03]), 'hC3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tCopySingle();
    tCopyRepeatUp();
    tCopyRepeatDown();
    tCmpSingle();
    tCmpRepeat();
    tCmpWrap();
    tBusyIgnore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule